// File: doc/BRIEF.md
# Ternary Flow Filter with Capture Copy

This block sits in a byte-wide packet pipeline. It forwards every packet it receives unchanged on a main output. It also checks a 104-bit flow key, taken from each packet's IPv4 header, against up to 32 ternary rules. Each rule holds a value, a mask and a valid bit. The rules are split into two banks of 16 entries that are searched in parallel, and their hit results are ORed. When a packet matches any rule, a second copy goes to a host-bound capture output. That copy is preceded by the packet's 64-bit arrival time, which comes from a side-channel input.

The block stores a whole packet before it sends anything, so the match decision is known before the first output byte. Rules are written at run time into a staging table. The whole staging table becomes the live rule set when the next packet's first byte is accepted, so each packet is judged against one consistent rule set.

All three streams use valid/ready with a last flag that marks the final byte. The input is accepted only while the block is receiving. Once a packet's last byte is accepted, `in_ready` stays low until that packet has fully left the main output. The main output honours back-pressure and holds its data steady while stalled. The capture output does not stall the block. During the data part of a copy, a capture byte is offered only in cycles where the main output accepts the same byte. If a capture byte is offered while `cap_ready` is low, the rest of that copy is abandoned and a drop counter advances. Packets are limited to 1 to `MAX_BYTES` bytes.

Top module: `flowcap_filter`

## Requirements
- R1: Every packet appears on the main output byte for byte, with `out_last` only on its final byte, whether it matches or not. Output data is held steady while `out_ready` is low.
- R2: A matching packet is sent on the capture output as 8 timestamp bytes, most significant byte first, followed by the packet bytes. `cap_last` is set only on the final packet byte.
- R3: A rule compares a key bit only where its mask bit is 1. A rule whose valid bit is 0 never matches. A valid rule with an all-zero mask matches every eligible packet.
- R4: The key is {source IP from bytes 12-15, destination IP from bytes 16-19, source port from bytes 20-21, destination port from bytes 22-23, protocol from byte 9}, big-endian, with the source IP in the top bits. A packet is eligible only when the upper nibble of byte 0 is 4 and the packet is at least 24 bytes long. Ineligible packets never match.
- R5: Bit 4 of `rule_idx` selects the bank and bits 3:0 select the entry. A hit in either bank causes a copy.
- R6: The timestamp in a copy is the value of `ts_in` in the cycle in which the packet's first byte is accepted.
- R7: A rule write becomes live when the next packet's first byte is accepted. A write made while a packet is in flight does not change that packet's decision.
- R8: If a capture byte is offered while `cap_ready` is low, no further capture bytes of that packet are offered and `drop_cnt` increments by one. The main output is not affected.
- R9: During the packet-data part of a copy, a capture byte is offered only in cycles where the main output is valid and ready.
- R10: After reset, no output is valid, `in_ready` is high, `drop_cnt` is 0 and no rule is valid.
- R11: `in_ready` is low from the cycle after a packet's last input byte until that packet has left the main output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Input packet byte |
| in_last | input | 1 | Final byte of the input packet |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts an input byte |
| ts_in | input | 64 | Free-running arrival time |
| out_data | output | 8 | Main output byte |
| out_last | output | 1 | Final byte on the main output |
| out_valid | output | 1 | Main output byte valid |
| out_ready | input | 1 | Main sink accepts a byte |
| cap_data | output | 8 | Capture output byte |
| cap_last | output | 1 | Final byte of the copy |
| cap_valid | output | 1 | Capture byte offered |
| cap_ready | input | 1 | Host accepts the capture byte |
| rule_we | input | 1 | Write one rule into the staging table |
| rule_idx | input | 5 | Rule index; bit 4 selects the bank |
| rule_value | input | 104 | Key value of the rule |
| rule_mask | input | 104 | Compare mask; 1 means compare |
| rule_valid | input | 1 | Valid bit of the rule |
| drop_cnt | output | 16 | Count of abandoned copies |

## Verification
The assertions check the following on every cycle:
- The main output holds its data while stalled.
- Input is refused while output is pending.
- `cap_last` coincides with `out_last`.
- A capture stall ends the copy on the next cycle, and `drop_cnt` never steps by more than one.
- The live rule set changes only at a commit, and then equals the staging table.

The bench sweeps many generated packets and checks the following, all computed from a bench model of the rules:
- The ternary matching itself.
- The key offsets.
- IPv4 and length eligibility.
- Which bank hit.
- The timestamp value and its byte order.
- The deferred effect of a rule written mid-packet.

// File: rtl/flowcap_pkg.sv
package flowcap_pkg;
  localparam int KEY_W = 104;
  localparam int OFS_PROTO = 9;
  localparam int OFS_SRC = 12;
  localparam int OFS_DST = 16;
  localparam int OFS_SPORT = 20;
  localparam int OFS_DPORT = 22;
  localparam int MIN_LEN = 24;

  typedef logic [KEY_W-1:0] key_t;

  typedef struct packed {
    logic vld;
    key_t val;
    key_t msk;
  } rule_t;

  typedef enum logic [1:0] {ST_RX, ST_EVAL, ST_STAMP, ST_SEND} phase_e;
endpackage

// File: rtl/flowcap_key_grab.sv
module flowcap_key_grab
  import flowcap_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       data,
  output key_t             key,
  output logic             is_v4
);
  logic [31:0] src_q, dst_q;
  logic [15:0] sport_q, dport_q;
  logic [7:0]  proto_q;

  function automatic logic in_span(input logic [IDX_W-1:0] i, input int lo, input int n);
    return (int'(i) >= lo) && (int'(i) < lo + n);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      sport_q <= '0;
      dport_q <= '0;
      proto_q <= '0;
      is_v4   <= 1'b0;
    end else if (beat) begin
      if (idx == '0) is_v4 <= (data[7:4] == 4'd4);
      if (int'(idx) == OFS_PROTO) proto_q <= data;
      if (in_span(idx, OFS_SRC, 4))   src_q   <= {src_q[23:0], data};
      if (in_span(idx, OFS_DST, 4))   dst_q   <= {dst_q[23:0], data};
      if (in_span(idx, OFS_SPORT, 2)) sport_q <= {sport_q[7:0], data};
      if (in_span(idx, OFS_DPORT, 2)) dport_q <= {dport_q[7:0], data};
    end
  end

  assign key = {src_q, dst_q, sport_q, dport_q, proto_q};
endmodule

// File: rtl/flowcap_tcam_bank.sv
module flowcap_tcam_bank
  import flowcap_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  rule_t         wr_rule,
  input  logic          commit,
  input  key_t          key,
  output logic          hit
);
  rule_t staged [ENTRIES];
  rule_t live   [ENTRIES];
  logic [ENTRIES-1:0] hit_vec, live_v, staged_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        staged[e] <= '0;
        live[e]   <= '0;
      end
    end else begin
      if (wr_en) staged[wr_idx] <= wr_rule;
      if (commit) begin
        for (int e = 0; e < ENTRIES; e++) live[e] <= staged[e];
      end
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cell
    assign hit_vec[e]  = live[e].vld && (((key ^ live[e].val) & live[e].msk) == '0);
    assign live_v[e]   = live[e].vld;
    assign staged_v[e] = staged[e].vld;
  end

  assign hit = |hit_vec;

  // R7: the live set only moves at a commit, and then copies the staging table
  assert_commit_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> live_v == $past(staged_v));
  assert_live_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(live_v));
endmodule

// File: rtl/flowcap_pkt_store.sv
module flowcap_pkt_store #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/flowcap_filter.sv
module flowcap_filter
  import flowcap_pkg::*;
#(
  parameter int MAX_BYTES    = 64,
  parameter int BANKS        = 2,
  parameter int BANK_ENTRIES = 16,
  parameter int TS_W         = 64,
  parameter int CNT_W        = 16,
  localparam int RULES    = BANKS * BANK_ENTRIES,
  localparam int IDX_W    = $clog2(RULES),
  localparam int BIW      = $clog2(BANK_ENTRIES),
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int AW       = $clog2(MAX_BYTES),
  localparam int TS_BYTES = TS_W / 8,
  localparam int TSC_W    = $clog2(TS_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TS_W-1:0]   ts_in,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        cap_data,
  output logic              cap_last,
  output logic              cap_valid,
  input  logic              cap_ready,
  input  logic              rule_we,
  input  logic [IDX_W-1:0]  rule_idx,
  input  logic [KEY_W-1:0]  rule_value,
  input  logic [KEY_W-1:0]  rule_mask,
  input  logic              rule_valid,
  output logic [CNT_W-1:0]  drop_cnt
);
  phase_e            phase;
  logic [LEN_W-1:0]  wr_cnt, rd_cnt, pkt_len;
  logic [TS_W-1:0]   ts_q;
  logic [TSC_W-1:0]  ts_sel;
  logic              copy_on;
  logic [CNT_W-1:0]  drop_q;
  logic              rx_beat, pkt_start, eligible, any_hit, cap_fail;
  logic [7:0]        rd_byte;
  key_t              key;
  logic              is_v4;
  logic [BANKS-1:0]  bank_hit;
  rule_t             wr_rule;

  assign in_ready  = (phase == ST_RX);
  assign rx_beat   = in_valid && in_ready;
  assign pkt_start = rx_beat && (wr_cnt == '0);

  flowcap_pkt_store #(.DEPTH(MAX_BYTES)) i_store (
    .clk   (clk),
    .we    (rx_beat && (int'(wr_cnt) < MAX_BYTES)),
    .waddr (wr_cnt[AW-1:0]),
    .wdata (in_data),
    .raddr (rd_cnt[AW-1:0]),
    .rdata (rd_byte)
  );

  flowcap_key_grab #(.IDX_W(LEN_W)) i_key (
    .clk   (clk),
    .rst_n (rst_n),
    .beat  (rx_beat),
    .idx   (wr_cnt),
    .data  (in_data),
    .key   (key),
    .is_v4 (is_v4)
  );

  assign wr_rule = '{vld: rule_valid, val: rule_value, msk: rule_mask};

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    flowcap_tcam_bank #(.ENTRIES(BANK_ENTRIES)) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (rule_we && ((int'(rule_idx) / BANK_ENTRIES) == b)),
      .wr_idx  (rule_idx[BIW-1:0]),
      .wr_rule (wr_rule),
      .commit  (pkt_start),
      .key     (key),
      .hit     (bank_hit[b])
    );
  end

  assign any_hit  = |bank_hit;
  assign eligible = is_v4 && (int'(pkt_len) >= MIN_LEN);

  assign out_valid = (phase == ST_SEND);
  assign out_data  = rd_byte;
  assign out_last  = out_valid && (rd_cnt == pkt_len - LEN_W'(1));

  assign cap_valid = copy_on && ((phase == ST_STAMP) || ((phase == ST_SEND) && out_ready));
  assign cap_data  = (phase == ST_STAMP) ? ts_q[TS_W-1 -: 8] : rd_byte;
  assign cap_last  = (phase == ST_SEND) && out_last;
  assign cap_fail  = cap_valid && !cap_ready;
  assign drop_cnt  = drop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= ST_RX;
      wr_cnt  <= '0;
      rd_cnt  <= '0;
      pkt_len <= '0;
      ts_q    <= '0;
      ts_sel  <= '0;
      copy_on <= 1'b0;
      drop_q  <= '0;
    end else begin
      unique case (phase)
        ST_RX: begin
          if (rx_beat) begin
            if (wr_cnt == '0) ts_q <= ts_in;
            wr_cnt <= wr_cnt + LEN_W'(1);
            if (in_last) begin
              pkt_len <= wr_cnt + LEN_W'(1);
              phase   <= ST_EVAL;
            end
          end
        end
        ST_EVAL: begin
          copy_on <= eligible && any_hit;
          rd_cnt  <= '0;
          ts_sel  <= '0;
          wr_cnt  <= '0;
          phase   <= (eligible && any_hit) ? ST_STAMP : ST_SEND;
        end
        ST_STAMP: begin
          if (cap_fail) begin
            copy_on <= 1'b0;
            drop_q  <= drop_q + CNT_W'(1);
            phase   <= ST_SEND;
          end else if (cap_ready) begin
            ts_q   <= ts_q << 8;
            ts_sel <= ts_sel + TSC_W'(1);
            if (int'(ts_sel) == TS_BYTES - 1) phase <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (cap_fail) begin
            copy_on <= 1'b0;
            drop_q  <= drop_q + CNT_W'(1);
          end
          if (out_ready) begin
            rd_cnt <= rd_cnt + LEN_W'(1);
            if (out_last) begin
              phase   <= ST_RX;
              copy_on <= 1'b0;
            end
          end
        end
        default: phase <= ST_RX;
      endcase
    end
  end

  assert_main_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  assert_busy_no_input_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  assert_last_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && cap_last) |-> (out_valid && out_last));
  assert_copy_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !cap_ready) |=> !cap_valid);
  assert_drop_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_cnt == $past(drop_cnt) || drop_cnt == $past(drop_cnt) + CNT_W'(1)));
endmodule

// File: tb/test_flowcap_filter.sv
module test_flowcap_filter;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   in_data = '0;
  logic         in_last = 1'b0, in_valid = 1'b0, in_ready;
  logic [63:0]  ts_in = 64'h0123_4567_89AB_0000;
  logic [7:0]   out_data, cap_data;
  logic         out_last, out_valid, cap_last, cap_valid;
  logic         out_ready = 1'b1, cap_ready = 1'b1;
  logic         rule_we = 1'b0, rule_valid = 1'b0;
  logic [4:0]   rule_idx = '0;
  logic [103:0] rule_value = '0, rule_mask = '0;
  logic [15:0]  drop_cnt;

  int total = 0, bad = 0, cyc = 0, r9_bad = 0;
  bit stall_main = 0, cap_block = 0;
  logic [7:0]   pkt [64];
  int           pkt_len_b;
  logic [63:0]  ts_exp;
  logic [8:0]   mq[$], cq[$];
  logic [103:0] m_val [32], m_msk [32];
  bit           m_vld [32];

  always #5 clk = ~clk;

  flowcap_filter i_flowcap_filter (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_last(in_last), .in_valid(in_valid),
    .in_ready(in_ready), .ts_in(ts_in), .out_data(out_data), .out_last(out_last),
    .out_valid(out_valid), .out_ready(out_ready), .cap_data(cap_data), .cap_last(cap_last),
    .cap_valid(cap_valid), .cap_ready(cap_ready), .rule_we(rule_we), .rule_idx(rule_idx),
    .rule_value(rule_value), .rule_mask(rule_mask), .rule_valid(rule_valid), .drop_cnt(drop_cnt)
  );

  always @(posedge clk) begin
    cyc       <= cyc + 1;
    ts_in     <= ts_in + 64'd8;
    out_ready <= stall_main ? ((cyc % 3) != 1) : 1'b1;
    cap_ready <= !cap_block;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) mq.push_back({out_last, out_data});
      if (cap_valid && cap_ready) cq.push_back({cap_last, cap_data});
      if (cap_valid && out_valid && !out_ready) r9_bad++;
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R1 act=hung exp=finished");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [103:0] key_of(input int k);
    logic [31:0] s, d;
    logic [15:0] sp, dp;
    logic [7:0]  pr;
    s  = 32'h0A00_0000 + 32'(k);
    d  = 32'hC0A8_0000 + 32'(k * 3);
    sp = 16'(1000 + k);
    dp = (k % 4 == 0) ? 16'd80 : 16'(2000 + k);
    pr = (k % 2 == 1) ? 8'd6 : 8'd17;
    return {s, d, sp, dp, pr};
  endfunction

  function automatic int len_of(input int k);
    return 20 + (k * 5) % 40;
  endfunction

  function automatic bit v4_of(input int k);
    return (k % 7) != 3;
  endfunction

  // R4: key fields at fixed header offsets, big-endian
  task automatic build(input int k, input int len);
    logic [103:0] kk;
    kk = key_of(k);
    pkt_len_b = len;
    for (int i = 0; i < 64; i++) pkt[i] = 8'(i * 29 + k * 7 + 3);
    pkt[0] = {(v4_of(k) ? 4'd4 : 4'd6), 4'd5};
    pkt[9] = kk[7:0];
    for (int i = 0; i < 4; i++) pkt[12 + i] = kk[103 - 8*i -: 8];
    for (int i = 0; i < 4; i++) pkt[16 + i] = kk[71 - 8*i -: 8];
    for (int i = 0; i < 2; i++) pkt[20 + i] = kk[39 - 8*i -: 8];
    for (int i = 0; i < 2; i++) pkt[22 + i] = kk[23 - 8*i -: 8];
  endtask

  function automatic bit model_hit(input int k, input int len);
    logic [103:0] kk;
    bit h;
    kk = key_of(k);
    h = 0;
    for (int r = 0; r < 32; r++)
      if (m_vld[r] && (((kk ^ m_val[r]) & m_msk[r]) == '0)) h = 1;
    return h && v4_of(k) && (len >= 24);
  endfunction

  task automatic write_rule(input int idx, input logic [103:0] v, input logic [103:0] m, input bit vl);
    rule_we = 1; rule_idx = 5'(idx); rule_value = v; rule_mask = m; rule_valid = vl;
    @(negedge clk);
    rule_we = 0;
    m_val[idx] = v; m_msk[idx] = m; m_vld[idx] = vl;
  endtask

  task automatic send_bytes();
    mq.delete(); cq.delete();
    for (int i = 0; i < pkt_len_b; i++) begin
      in_valid = 1; in_data = pkt[i]; in_last = (i == pkt_len_b - 1);
      while (!in_ready) @(negedge clk);
      if (i == 0) ts_exp = ts_in;
      @(negedge clk);
    end
    in_valid = 0; in_last = 0;
    chk(in_ready == 0, "R11", "in_ready after last byte", in_ready, 0);
  endtask

  task automatic drain();
    for (int w = 0; w < 2000 && mq.size() < pkt_len_b; w++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_main(input string tag);
    bit ok;
    ok = (mq.size() == pkt_len_b);
    for (int i = 0; ok && i < pkt_len_b; i++)
      if (mq[i] != {(i == pkt_len_b - 1), pkt[i]}) ok = 0;
    chk(ok, "R1", tag, mq.size(), pkt_len_b);
  endtask

  task automatic check_cap(input bit exp_hit, input string req, input string tag);
    bit ok;
    if (!exp_hit) begin
      chk(cq.size() == 0, req, tag, cq.size(), 0);
    end else begin
      ok = (cq.size() == pkt_len_b + 8);
      for (int i = 0; ok && i < 8; i++)
        if (cq[i] != {1'b0, ts_exp[63 - 8*i -: 8]}) ok = 0;
      chk(ok, "R6", {tag, " timestamp"}, cq.size(), pkt_len_b + 8);
      for (int i = 0; ok && i < pkt_len_b; i++)
        if (cq[8 + i] != {(i == pkt_len_b - 1), pkt[i]}) ok = 0;
      chk(ok, "R2", {tag, " copy"}, cq.size(), pkt_len_b + 8);
    end
  endtask

  task automatic run_pkt(input int k, input int len, input string req, input string tag);
    bit eh;
    eh = model_hit(k, len);
    build(k, len);
    send_bytes();
    drain();
    check_main(tag);
    check_cap(eh, req, tag);
  endtask

  initial begin
    logic [15:0] d0;
    int n;
    bit ok;
    for (int r = 0; r < 32; r++) begin m_vld[r] = 0; m_val[r] = '0; m_msk[r] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    chk(out_valid == 0 && cap_valid == 0, "R10", "outputs idle", {out_valid, cap_valid}, 0);
    chk(in_ready == 1, "R10", "in_ready", in_ready, 1);
    chk(drop_cnt == 0, "R10", "drop_cnt", drop_cnt, 0);
    run_pkt(1, 40, "R10", "no rules after reset");

    // R3 R5: exact rule in bank 0, exact rule and port-only rule in bank 1, invalid entry
    write_rule(3, key_of(5), {104{1'b1}}, 1);
    write_rule(16, key_of(11), {104{1'b1}}, 1);
    write_rule(20, {80'd0, 16'd80, 8'd0}, {80'd0, 16'hFFFF, 8'd0}, 1);
    write_rule(5, key_of(6), {104{1'b1}}, 0);
    for (int k = 0; k < 24; k++) begin
      stall_main = (k % 2 == 1);
      run_pkt(k, len_of(k), "R5", $sformatf("sweep k=%0d", k));
    end
    stall_main = 0;
    chk(r9_bad == 0, "R9", "capture offered while main stalled", r9_bad, 0);

    // R3 R4: wildcard rule, length and version eligibility
    write_rule(31, '0, '0, 1);
    run_pkt(2, 23, "R4", "23-byte packet");
    run_pkt(2, 24, "R3", "wildcard 24-byte");
    run_pkt(3, 35, "R4", "non-IPv4");
    write_rule(31, '0, '0, 0);
    run_pkt(2, 30, "R3", "wildcard removed");

    // R7: rule written mid-packet does not affect that packet
    build(7, len_of(7));
    fork
      send_bytes();
      begin repeat (4) @(negedge clk); write_rule(8, key_of(7), {104{1'b1}}, 1); end
    join
    drain();
    check_main("mid-packet write");
    chk(cq.size() == 0, "R7", "mid-packet write no copy", cq.size(), 0);
    run_pkt(7, len_of(7), "R7", "rule live next packet");

    // R8: capture stalled during timestamp
    d0 = drop_cnt;
    cap_block = 1;
    @(negedge clk);
    build(5, len_of(5));
    send_bytes();
    drain();
    check_main("drop in stamp");
    chk(cq.size() == 0, "R8", "copy abandoned", cq.size(), 0);
    chk(drop_cnt == d0 + 16'd1, "R8", "drop count", drop_cnt, d0 + 16'd1);
    cap_block = 0;
    @(negedge clk);

    // R8: capture stalled part-way through data
    d0 = drop_cnt;
    build(5, len_of(5));
    fork
      send_bytes();
      begin
        for (int w = 0; w < 3000 && cq.size() < 11; w++) @(negedge clk);
        cap_block = 1;
      end
    join
    drain();
    check_main("drop in data");
    n = cq.size();
    ok = (n >= 11) && (n < pkt_len_b + 8);
    for (int i = 0; ok && i < n; i++)
      if (cq[i] != (i < 8 ? {1'b0, ts_exp[63 - 8*i -: 8]} : {1'b0, pkt[i - 8]})) ok = 0;
    chk(ok, "R8", "truncated prefix", n, 11);
    chk(drop_cnt == d0 + 16'd1, "R8", "drop count mid", drop_cnt, d0 + 16'd1);
    cap_block = 0;
    @(negedge clk);
    run_pkt(4, len_of(4), "R2", "copy after drop");

    summary();
    $finish;
  end
endmodule